// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog timer with a small register interface of three 32-bit words: a control/status word, a counter word and a timeout-limit word. While the enable bit is set, the count advances by one on every cycle in which the tick enable input is high. If software stops servicing the block and the count reaches the programmed limit, the block raises a reset request for one cycle. It then freezes until the next reset.

Software cannot change the control or limit words directly. It must first write a magic unlock key to the counter word. This opens a short window in which one configuration write is accepted. Servicing also uses the counter word: software writes a separate refresh key there. Either key can be given as one 32-bit word or as two 16-bit halves in a fixed order, depending on a mode bit in the control word. A wrong key cancels any half-entered sequence and sets a sticky error flag.

If a configuration write leaves the update-permit bit cleared, the block accepts no further unlock until reset. With a 1 kHz tick, a timeout of N seconds (N from 1 to 128) is programmed as 1000×N ticks.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, a read of the control word returns 0x00002020 (32-bit key mode and update-permit set). A read of the count returns 0, a read of the limit returns LIMIT_RST (default 1000), and the reset request is low.
- R2: In 32-bit key mode (control bit 13 = 1), writing 0xD928C520 to offset 0x4 unlocks the block. Control bit 11 reads 1 while the block is unlocked.
- R3: In 16-bit key mode (control bit 13 = 0), only the low 16 bits of a counter write are used. The two writes 0xC520 then 0xD928 unlock the block. The two writes 0xA602 then 0xB480 form the refresh key.
- R4: Writes to the control word (offset 0x0) and the limit word (offset 0x8) take effect only while the block is unlocked; at other times they are ignored. The window closes at the first such write, or after 255 cycles without one. Control bit 10 reads 1 after an accepted write and is cleared by the next unlock.
- R5: A counter write that matches no key, or a second 16-bit half that does not complete the sequence begun by the first half, abandons the sequence. It sets the sticky error flag in control bit 14, which is cleared only by reset, and leaves the count unchanged.
- R6: If control bit 5 (update-permit) is 0 once an accepted configuration write completes, every later unlock key is ignored until reset.
- R7: While control bit 7 (enable) is 1, the count increments on each cycle with tick_en high, and the refresh key 0xB480A602 (32-bit mode) sets the count to 0. While bit 7 is 0, the count holds and the refresh key has no effect.
- R8: When the block is enabled and the count equals the limit, the reset request goes high for exactly one cycle. The count then stays frozen until reset. A limit of 5 with tick_en held high gives the request on the 6th clock edge after enabling.
- R9: A read returns its data on rd_data one cycle after rd_en. The control word is laid out as follows:
  - writable fields: bits 13, 9:8 (clock source select), 7, 5, 1 (run in wait mode) and 0 (run in stop mode);
  - read-only flags: bits 14, 11 and 10;
  - all other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Registered read data |
| wdog_rst | output | 1 | One-cycle reset request |

## Verification
Each key or configuration write changes state at the clock edge that samples it. Every read therefore starts in the cycle after a write and is checked one edge later, once rd_data has been registered. The reset request is due a known number of edges after the enabling write: limit plus one when tick_en stays high. The bench counts edges from that write, samples at falling edges, and compares the count with the expected number. The window limit is checked by idling well past 255 cycles before trying a write.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned OFF_CTRL  = 0;
  localparam int unsigned OFF_COUNT = 4;
  localparam int unsigned OFF_LIMIT = 8;

  localparam logic [31:0] KEY_OPEN_W  = 32'hD928_C520;
  localparam logic [31:0] KEY_FEED_W  = 32'hB480_A602;
  localparam logic [15:0] KEY_OPEN_A  = 16'hC520;
  localparam logic [15:0] KEY_OPEN_B  = 16'hD928;
  localparam logic [15:0] KEY_FEED_A  = 16'hA602;
  localparam logic [15:0] KEY_FEED_B  = 16'hB480;

  localparam int unsigned B_ERR    = 14;
  localparam int unsigned B_WIDE   = 13;
  localparam int unsigned B_OPEN   = 11;
  localparam int unsigned B_DONE   = 10;
  localparam int unsigned B_RUN    = 7;
  localparam int unsigned B_PERMIT = 5;

  localparam logic [31:0] CTRL_WMASK = 32'h0000_23A3;
  localparam logic [31:0] CTRL_RST   = 32'h0000_2020;

  typedef enum logic [1:0] {
    HALF_NONE = 2'd0,
    HALF_OPEN = 2'd1,
    HALF_FEED = 2'd2
  } half_t;
endpackage

// File: rtl/wdg_keys.sv
module wdg_keys
  import wdg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              open_hit,
  output logic              feed_hit,
  output logic              err_flag
);
  half_t half_q, half_d;
  logic  cnt_wr, bad;

  assign cnt_wr = wr_en && (wr_addr == ADDR_W'(OFF_COUNT));

  always_comb begin
    open_hit = 1'b0;
    feed_hit = 1'b0;
    bad      = 1'b0;
    half_d   = half_q;
    if (cnt_wr) begin
      if (wide_mode) begin
        half_d = HALF_NONE;
        if (wr_data == KEY_OPEN_W)      open_hit = 1'b1;
        else if (wr_data == KEY_FEED_W) feed_hit = 1'b1;
        else                            bad      = 1'b1;
      end else begin
        unique case (half_q)
          HALF_OPEN: begin
            half_d = HALF_NONE;
            if (wr_data[15:0] == KEY_OPEN_B) open_hit = 1'b1;
            else                             bad      = 1'b1;
          end
          HALF_FEED: begin
            half_d = HALF_NONE;
            if (wr_data[15:0] == KEY_FEED_B) feed_hit = 1'b1;
            else                             bad      = 1'b1;
          end
          default: begin
            if (wr_data[15:0] == KEY_OPEN_A)      half_d = HALF_OPEN;
            else if (wr_data[15:0] == KEY_FEED_A) half_d = HALF_FEED;
            else begin
              half_d = HALF_NONE;
              bad    = 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q   <= HALF_NONE;
      err_flag <= 1'b0;
    end else begin
      half_q <= half_d;
      if (bad) err_flag <= 1'b1;
    end
  end

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
  p_half_cleared_wide_r3: assert property (@(posedge clk) disable iff (rst)
    wide_mode |=> (half_q == HALF_NONE));
endmodule

// File: rtl/wdg_cfg.sv
module wdg_cfg
  import wdg_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int CNT_W         = 32,
  parameter int UNLOCK_CYCLES = 255,
  parameter logic [CNT_W-1:0] LIMIT_RST = CNT_W'(1000)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              open_hit,
  output logic [31:0]       ctrl_q,
  output logic [CNT_W-1:0]  limit_q,
  output logic              unlocked,
  output logic              done,
  output logic              frozen
);
  localparam int WIN_W = $clog2(UNLOCK_CYCLES + 1);

  logic [WIN_W-1:0] win_q;
  logic             to_ctrl, to_limit, apply, next_permit;

  assign to_ctrl     = wr_en && (wr_addr == ADDR_W'(OFF_CTRL));
  assign to_limit    = wr_en && (wr_addr == ADDR_W'(OFF_LIMIT));
  assign apply       = unlocked && (to_ctrl || to_limit);
  assign next_permit = to_ctrl ? wr_data[B_PERMIT] : ctrl_q[B_PERMIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= CTRL_RST;
      limit_q  <= LIMIT_RST;
      unlocked <= 1'b0;
      done     <= 1'b0;
      frozen   <= 1'b0;
      win_q    <= '0;
    end else if (apply) begin
      if (to_ctrl)  ctrl_q  <= wr_data & CTRL_WMASK;
      if (to_limit) limit_q <= wr_data[CNT_W-1:0];
      unlocked <= 1'b0;
      done     <= 1'b1;
      if (!next_permit) frozen <= 1'b1;
    end else if (open_hit && !frozen) begin
      unlocked <= 1'b1;
      done     <= 1'b0;
      win_q    <= '0;
    end else if (unlocked) begin
      if (win_q == WIN_W'(UNLOCK_CYCLES - 1)) unlocked <= 1'b0;
      else                                    win_q    <= win_q + 1'b1;
    end
  end

  p_cfg_needs_unlock_r4: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> ($stable(limit_q) && $stable(ctrl_q)));
  p_frozen_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    frozen |=> frozen);
  p_frozen_no_open_r6: assert property (@(posedge clk) disable iff (rst)
    (frozen && !unlocked) |=> !unlocked);
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick_en,
  input  logic             feed,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count_q,
  output logic             fire
);
  logic halted;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      halted  <= 1'b0;
      fire    <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (run && !halted) begin
        if (feed) begin
          count_q <= '0;
        end else if (count_q == limit) begin
          halted <= 1'b1;
          fire   <= 1'b1;
        end else if (tick_en) begin
          count_q <= count_q + 1'b1;
        end
      end
    end
  end

  p_fire_single_r8: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
  p_halt_freezes_r8: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(count_q));
  p_idle_holds_r7: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(count_q));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdg_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int CNT_W         = 32,
  parameter int UNLOCK_CYCLES = 255,
  parameter logic [CNT_W-1:0] LIMIT_RST = CNT_W'(1000)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              wdog_rst
);
  logic [31:0]      ctrl_q, ctrl_view;
  logic [CNT_W-1:0] limit_q, count_q;
  logic             open_hit, feed_hit, err_flag;
  logic             unlocked, done, frozen;

  wdg_keys #(.ADDR_W(ADDR_W)) u_keys (
    .clk      (clk),
    .rst      (rst),
    .wide_mode(ctrl_q[B_WIDE]),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .open_hit (open_hit),
    .feed_hit (feed_hit),
    .err_flag (err_flag)
  );

  wdg_cfg #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .UNLOCK_CYCLES(UNLOCK_CYCLES), .LIMIT_RST(LIMIT_RST)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .open_hit(open_hit),
    .ctrl_q  (ctrl_q),
    .limit_q (limit_q),
    .unlocked(unlocked),
    .done    (done),
    .frozen  (frozen)
  );

  wdg_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst    (rst),
    .run    (ctrl_q[B_RUN]),
    .tick_en(tick_en),
    .feed   (feed_hit),
    .limit  (limit_q),
    .count_q(count_q),
    .fire   (wdog_rst)
  );

  always_comb begin
    ctrl_view         = ctrl_q & CTRL_WMASK;
    ctrl_view[B_ERR]  = err_flag;
    ctrl_view[B_OPEN] = unlocked;
    ctrl_view[B_DONE] = done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (rd_addr == ADDR_W'(OFF_CTRL))       rd_data <= ctrl_view;
      else if (rd_addr == ADDR_W'(OFF_COUNT)) rd_data <= 32'(count_q);
      else if (rd_addr == ADDR_W'(OFF_LIMIT)) rd_data <= 32'(limit_q);
      else                                    rd_data <= '0;
    end
  end

  p_fire_needs_run_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(wdog_rst) |-> $past(ctrl_q[B_RUN]));
endmodule

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        wdog_rst;
  int          errors = 0;
  int          checks = 0;

  always #2 clk = ~clk;

  keyed_watchdog uut (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wdog_rst(wdog_rst)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(4'h0, v); check("R1 ctrl after reset", v, 32'h0000_2020);
    rd(4'h4, v); check("R1 count after reset", v, 32'd0);
    rd(4'h8, v); check("R1 limit after reset", v, 32'd1000);
    check("R1 reset request low", {31'b0, wdog_rst}, 32'd0);
  endtask

  task automatic t_unlock_wide();
    logic [31:0] v;
    do_reset();
    wr(4'h4, 32'hD928_C520);
    rd(4'h0, v); check("R2 unlocked flag bit 11", v, 32'h0000_2820);
    wr(4'h8, 32'd5);
    rd(4'h8, v); check("R4 limit accepted", v, 32'd5);
    rd(4'h0, v); check("R4 done set, window closed", v, 32'h0000_2420);
    wr(4'h8, 32'd7);
    rd(4'h8, v); check("R4 limit write without unlock ignored", v, 32'd5);
    wr(4'h4, 32'hD928_C520);
    rd(4'h0, v); check("R4 done cleared by new unlock", v, 32'h0000_2820);
  endtask

  task automatic t_window();
    logic [31:0] v;
    do_reset();
    wr(4'h4, 32'hD928_C520);
    repeat (300) @(posedge clk);
    rd(4'h0, v); check("R4 window expired", v, 32'h0000_2020);
    wr(4'h8, 32'd9);
    rd(4'h8, v); check("R4 late limit write ignored", v, 32'd1000);
  endtask

  task automatic t_narrow();
    logic [31:0] v;
    do_reset();
    wr(4'h4, 32'hD928_C520);
    wr(4'h0, 32'h0000_00A0);
    ticks(3);
    rd(4'h4, v); check("R7 count follows ticks", v, 32'd3);
    wr(4'h4, 32'h0000_A602);
    wr(4'h4, 32'h0000_B480);
    rd(4'h4, v); check("R3 two-half refresh clears count", v, 32'd0);
    ticks(2);
    wr(4'h4, 32'h0000_A602);
    wr(4'h4, 32'h0000_1234);
    rd(4'h4, v); check("R5 broken half keeps count", v, 32'd2);
    rd(4'h0, v); check("R5 error flag after broken half", v & 32'h0000_4000, 32'h0000_4000);
    wr(4'h4, 32'h0000_C520);
    wr(4'h4, 32'h0000_D928);
    rd(4'h0, v); check("R3 two-half unlock", v, 32'h0000_48A0);
  endtask

  task automatic t_wrong_key();
    logic [31:0] v;
    do_reset();
    wr(4'h4, 32'h1234_5678);
    rd(4'h0, v); check("R5 error flag set", v, 32'h0000_6020);
    rd(4'h4, v); check("R5 count unchanged", v, 32'd0);
    wr(4'h4, 32'hD928_C520);
    rd(4'h0, v); check("R5 error flag sticky", v, 32'h0000_6820);
  endtask

  task automatic t_disabled_feed();
    logic [31:0] v;
    do_reset();
    wr(4'h4, 32'hD928_C520);
    wr(4'h0, 32'h0000_20A0);
    ticks(4);
    wr(4'h4, 32'hD928_C520);
    wr(4'h0, 32'h0000_2020);
    ticks(3);
    rd(4'h4, v); check("R7 disabled count holds", v, 32'd4);
    wr(4'h4, 32'hB480_A602);
    rd(4'h4, v); check("R7 refresh ignored while disabled", v, 32'd4);
  endtask

  task automatic t_lockout();
    logic [31:0] v;
    do_reset();
    wr(4'h4, 32'hD928_C520);
    wr(4'h0, 32'h0000_2000);
    wr(4'h4, 32'hD928_C520);
    rd(4'h0, v); check("R6 unlock refused after lockout", v, 32'h0000_2400);
    wr(4'h8, 32'd3);
    rd(4'h8, v); check("R6 limit unchanged after lockout", v, 32'd1000);
  endtask

  task automatic t_fire();
    logic [31:0] v;
    int n;
    do_reset();
    wr(4'h4, 32'hD928_C520);
    wr(4'h8, 32'd5);
    wr(4'h4, 32'hD928_C520);
    wr(4'h0, 32'h0000_20A0);
    tick_en = 1'b1;
    n = 0;
    while (n < 20) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (wdog_rst) break;
    end
    check("R8 request edge count", n, 6);
    @(posedge clk);
    @(negedge clk);
    check("R8 request one cycle wide", {31'b0, wdog_rst}, 32'd0);
    repeat (5) @(posedge clk);
    tick_en = 1'b0;
    wr(4'h4, 32'hB480_A602);
    rd(4'h4, v); check("R8 count frozen after request", v, 32'd5);
    rd(4'h0, v); check("R9 ctrl layout after run", v, 32'h0000_24A0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_unlock_wide();
    t_window();
    t_narrow();
    t_wrong_key();
    t_disabled_feed();
    t_lockout();
    t_fire();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule